// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This controller gathers a bank of interrupt request lines, arranged as a fixed number of groups with an equal number of lines in each, and presents a single prioritized request to a CPU. Each line passes through a two-flop synchronizer and is then captured into a per-group request register that software can read. The lines of a group are ORed into one pending signal per group. A per-group priority register assigns that group one of four levels and a handler offset. The CPU status bits supply one mask per level and a global mask. These masks gate the pending signals into per-group valid requests.

For every level, the lowest-numbered group with a valid request at that level wins. Its offset is stored in a per-level cause register. The highest level that has a winner drives the CPU request, level and offset outputs. A separate non-maskable request bypasses every mask and takes the top level with a fixed offset. The hardware never chooses between lines inside one group. The service routine reads the group's request register and makes that choice itself. The controller has no debug-mode input, so it behaves the same whether or not the CPU is halted.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Line `g*GROUP_LINES+j` appears in bit j of group g's request register three clock edges after it changes. The request register of group g is read at address `0x40+g`.
- R2: `valid_req[g]` is high only when at least one line of group g is captured high, the level mask bit for the group's level is clear, and `glob_mask` is clear. It follows the request registers and the mask inputs without extra delay.
- R3: Group g's priority register is at address `0x00+g`. Its level is in bits [OFFSET_W+1:OFFSET_W] and its offset is in bits [OFFSET_W-1:0]. It resets to level 0 and offset 0. A write takes effect at the write edge and reads back unchanged.
- R4: The cause register of level l is at address `0x80+l`. One edge after the valid requests settle, it holds the offset of the lowest-numbered valid group at level l, with bit OFFSET_W set. It reads 0 when level l has no valid group.
- R5: One edge after the valid requests settle, `cpu_req` is high exactly when some level has a winner. `cpu_level` and `cpu_offset` then give the highest such level and the offset of that level's winner.
- R6: Setting `lvl_mask[l]` removes every group at level l from `valid_req`. Setting `glob_mask` removes every group.
- R7: `nmi_in` reaches the outputs four edges after it rises, whatever the masks are. While it is captured, `cpu_req` and `cpu_nmi` are high, `cpu_level` is 3 and `cpu_offset` is `NMI_OFFSET`.
- R8: Writes to the request or cause regions (address bits [7:6] equal to 01 or 10) leave every register and output unchanged.
- R9: Several active lines in one group give the same valid request and offset as a single line. The request register shows all of the active lines.
- R10: After reset, `cpu_req`, `cpu_nmi`, `cpu_level`, `cpu_offset` and `valid_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_GROUPS*GROUP_LINES | Asynchronous interrupt request lines, grouped by consecutive index |
| nmi_in | input | 1 | Non-maskable request |
| lvl_mask | input | 4 | Per-level mask bits from the CPU status register |
| glob_mask | input | 1 | Global mask bit from the CPU status register |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: bits [7:6] select the region and the low bits select the index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, available in the same cycle as the address |
| valid_req | output | NUM_GROUPS | Per-group unmasked request |
| cpu_req | output | 1 | Request to the CPU |
| cpu_nmi | output | 1 | The request is the non-maskable one |
| cpu_level | output | 2 | Level of the request |
| cpu_offset | output | OFFSET_W | Handler offset of the request |

## Verification
A line change takes three edges to reach the request registers and `valid_req`, and four edges to reach the cause registers and CPU outputs. A mask change or a priority write affects `valid_req` straight after the change and the CPU outputs one edge later. The bench drives every input on the falling edge. It then waits exactly that number of rising edges before it samples, again on a falling edge. Some checks sample one edge early to confirm that a result has not arrived before it is due.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int NUM_LEVELS = 4;
    localparam int LVL_W      = 2;

    typedef enum logic [1:0] {
        RGN_PRIO  = 2'd0,
        RGN_REQ   = 2'd1,
        RGN_CAUSE = 2'd2,
        RGN_NONE  = 2'd3
    } region_e;
endpackage

// File: rtl/grp_irq_sync.sv
module grp_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/grp_irq_arb.sv
module grp_irq_arb
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int OFFSET_W   = 8
) (
    input  logic [NUM_GROUPS-1:0]          valid,
    input  logic [NUM_GROUPS*LVL_W-1:0]    lvl_flat,
    input  logic [NUM_GROUPS*OFFSET_W-1:0] off_flat,
    output logic [NUM_LEVELS-1:0]          found,
    output logic [NUM_LEVELS*OFFSET_W-1:0] win_off
);
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
        logic                f_lvl;
        logic [OFFSET_W-1:0] o_lvl;

        // scan downward so the lowest-numbered group is written last
        always_comb begin
            f_lvl = 1'b0;
            o_lvl = '0;
            for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
                if (valid[g] && (lvl_flat[g*LVL_W +: LVL_W] == LVL_W'(l))) begin
                    f_lvl = 1'b1;
                    o_lvl = off_flat[g*OFFSET_W +: OFFSET_W];
                end
            end
        end

        assign found[l]                      = f_lvl;
        assign win_off[l*OFFSET_W +: OFFSET_W] = o_lvl;
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int                NUM_GROUPS  = 4,
    parameter int                GROUP_LINES = 4,
    parameter int                OFFSET_W    = 8,
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [OFFSET_W-1:0] NMI_OFFSET = 8'hFC
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS*GROUP_LINES-1:0] irq_in,
    input  logic                            nmi_in,
    input  logic [3:0]                      lvl_mask,
    input  logic                            glob_mask,
    input  logic                            reg_we,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic [NUM_GROUPS-1:0]           valid_req,
    output logic                            cpu_req,
    output logic                            cpu_nmi,
    output logic [1:0]                      cpu_level,
    output logic [OFFSET_W-1:0]             cpu_offset
);
    localparam int NUM_LINES = NUM_GROUPS * GROUP_LINES;
    localparam int IDX_W     = ADDR_W - 2;

    typedef struct packed {
        logic [NUM_LINES-1:0]                 irr;
        logic                                 nmi;
        logic [NUM_GROUPS-1:0][LVL_W-1:0]     prio_lvl;
        logic [NUM_GROUPS-1:0][OFFSET_W-1:0]  prio_off;
        logic [NUM_LEVELS-1:0]                cause_vld;
        logic [NUM_LEVELS-1:0][OFFSET_W-1:0]  cause_off;
        logic                                 cpu_req;
        logic                                 cpu_nmi;
        logic [LVL_W-1:0]                     cpu_lvl;
        logic [OFFSET_W-1:0]                  cpu_off;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES:0]              sync_q;
    logic [NUM_LINES-1:0]            irr_live;
    logic [NUM_GROUPS-1:0]           grp_pend;
    logic [NUM_GROUPS-1:0]           valid_w;
    logic [NUM_GROUPS*LVL_W-1:0]     lvl_flat;
    logic [NUM_GROUPS*OFFSET_W-1:0]  off_flat;
    logic [NUM_LEVELS-1:0]           found;
    logic [NUM_LEVELS*OFFSET_W-1:0]  win_off;
    region_e                         region;
    logic [IDX_W-1:0]                idx;
    logic                            unused_bits;

    grp_irq_sync #(.W(NUM_LINES + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_in, irq_in}),
        .q     (sync_q)
    );

    assign irr_live = st_q.irr;
    assign lvl_flat = st_q.prio_lvl;
    assign off_flat = st_q.prio_off;
    assign region   = region_e'(reg_addr[ADDR_W-1 -: 2]);
    assign idx      = reg_addr[IDX_W-1:0];
    assign unused_bits = ^reg_wdata[DATA_W-1:OFFSET_W+2];

    // group OR and mask gating
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            grp_pend[g] = |irr_live[g*GROUP_LINES +: GROUP_LINES];
            valid_w[g]  = grp_pend[g] && !lvl_mask[st_q.prio_lvl[g]] && !glob_mask;
        end
    end

    grp_irq_arb #(.NUM_GROUPS(NUM_GROUPS), .OFFSET_W(OFFSET_W)) u_arb (
        .valid    (valid_w),
        .lvl_flat (lvl_flat),
        .off_flat (off_flat),
        .found    (found),
        .win_off  (win_off)
    );

    // next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.irr = sync_q[NUM_LINES-1:0];
        st_d.nmi = sync_q[NUM_LINES];

        if (reg_we && region == RGN_PRIO) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (int'(idx) == g) begin
                    st_d.prio_lvl[g] = reg_wdata[OFFSET_W+1:OFFSET_W];
                    st_d.prio_off[g] = reg_wdata[OFFSET_W-1:0];
                end
            end
        end

        for (int l = 0; l < NUM_LEVELS; l++) begin
            st_d.cause_vld[l] = found[l];
            st_d.cause_off[l] = win_off[l*OFFSET_W +: OFFSET_W];
        end

        st_d.cpu_req = 1'b0;
        st_d.cpu_nmi = 1'b0;
        st_d.cpu_lvl = '0;
        st_d.cpu_off = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (found[l]) begin
                st_d.cpu_req = 1'b1;
                st_d.cpu_lvl = LVL_W'(l);
                st_d.cpu_off = win_off[l*OFFSET_W +: OFFSET_W];
            end
        end
        if (st_q.nmi) begin
            st_d.cpu_req = 1'b1;
            st_d.cpu_nmi = 1'b1;
            st_d.cpu_lvl = LVL_W'(NUM_LEVELS - 1);
            st_d.cpu_off = NMI_OFFSET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (region)
            RGN_PRIO: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (int'(idx) == g) begin
                        reg_rdata[OFFSET_W+1:OFFSET_W] = st_q.prio_lvl[g];
                        reg_rdata[OFFSET_W-1:0]        = st_q.prio_off[g];
                    end
                end
            end
            RGN_REQ: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (int'(idx) == g)
                        reg_rdata[GROUP_LINES-1:0] = irr_live[g*GROUP_LINES +: GROUP_LINES];
                end
            end
            RGN_CAUSE: begin
                for (int l = 0; l < NUM_LEVELS; l++) begin
                    if (int'(idx) == l) begin
                        reg_rdata[OFFSET_W]     = st_q.cause_vld[l];
                        reg_rdata[OFFSET_W-1:0] = st_q.cause_off[l];
                    end
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    assign valid_req  = valid_w;
    assign cpu_req    = st_q.cpu_req;
    assign cpu_nmi    = st_q.cpu_nmi;
    assign cpu_level  = st_q.cpu_lvl;
    assign cpu_offset = st_q.cpu_off;
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
    parameter int NUM_GROUPS  = 4,
    parameter int GROUP_LINES = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_GROUPS*GROUP_LINES-1:0] irq_in,
    input logic                              glob_mask,
    input logic [NUM_GROUPS-1:0]             valid_req,
    input logic                              cpu_req,
    input logic                              cpu_nmi,
    input logic [1:0]                        cpu_level,
    input logic [NUM_GROUPS*GROUP_LINES-1:0] irr
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_IRR_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (irr == $past(irq_in, 3))); // R1

    AST_GLOBAL_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        glob_mask |-> (valid_req == '0)); // R6

    AST_NMI_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_nmi |-> (cpu_req && cpu_level == 2'd3)); // R7

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_nmi) |-> $past(|valid_req)); // R5

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        AST_VALID_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            valid_req[g] |-> (|irr[g*GROUP_LINES +: GROUP_LINES])); // R2
    end
endmodule

bind grp_irq_ctrl grp_irq_chk #(
    .NUM_GROUPS  (NUM_GROUPS),
    .GROUP_LINES (GROUP_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .glob_mask (glob_mask),
    .valid_req (valid_req),
    .cpu_req   (cpu_req),
    .cpu_nmi   (cpu_nmi),
    .cpu_level (cpu_level),
    .irr       (irr_live)
);

// File: tb/tb_grp_irq_ctrl.sv
module tb_grp_irq_ctrl;
    localparam int G  = 4;
    localparam int L  = 4;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [G*L-1:0] irq_in = '0;
    logic          nmi_in = 1'b0;
    logic [3:0]    lvl_mask = 4'h0;
    logic          glob_mask = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [G-1:0]  valid_req;
    logic          cpu_req, cpu_nmi;
    logic [1:0]    cpu_level;
    logic [OW-1:0] cpu_offset;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    grp_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .lvl_mask(lvl_mask), .glob_mask(glob_mask), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .valid_req(valid_req), .cpu_req(cpu_req), .cpu_nmi(cpu_nmi),
        .cpu_level(cpu_level), .cpu_offset(cpu_offset)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_cpu(input string req, input logic r, input logic n, input logic [1:0] lv, input logic [OW-1:0] o);
        chk(cpu_req == r, req, 32'(cpu_req), 32'(r));
        chk(cpu_nmi == n, req, 32'(cpu_nmi), 32'(n));
        if (r) begin
            chk(cpu_level == lv, req, 32'(cpu_level), 32'(lv));
            chk(cpu_offset == o, req, 32'(cpu_offset), 32'(o));
        end
    endtask

    task automatic settle();
        irq_in = '0; nmi_in = 1'b0; lvl_mask = '0; glob_mask = 1'b0;
        tick(5);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk_cpu("R10", 1'b0, 1'b0, 2'd0, '0);
        chk(valid_req == '0, "R10", 32'(valid_req), 0);
        chk(cpu_level == 2'd0 && cpu_offset == '0, "R10", {cpu_level, cpu_offset}, 0);
        for (int g = 0; g < G; g++) begin
            rd(8'h00 + 8'(g), d);
            chk(d == 0, "R3 reset", d, 0);
        end
    endtask

    task automatic t_single();
        logic [31:0] d;
        wr(8'h01, 32'h0000_0224);
        rd(8'h01, d);
        chk(d == 32'h224, "R3 readback", d, 32'h224);
        irq_in = 16'h0020;
        tick(2);
        chk(valid_req == '0, "R1 early", 32'(valid_req), 0);
        tick(1);
        chk(valid_req == 4'b0010, "R2", 32'(valid_req), 4'b0010);
        rd(8'h41, d);
        chk(d == 32'h2, "R1", d, 32'h2);
        chk(cpu_req == 1'b0, "R5 early", 32'(cpu_req), 0);
        tick(1);
        chk_cpu("R5", 1'b1, 1'b0, 2'd2, 8'h24);
        rd(8'h82, d);
        chk(d == 32'h124, "R4", d, 32'h124);
        rd(8'h81, d);
        chk(d == 0, "R4 empty", d, 0);
        settle();
    endtask

    task automatic t_lowest();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0110);
        wr(8'h02, 32'h0000_0130);
        wr(8'h03, 32'h0000_0350);
        irq_in = 16'h0401;
        tick(4);
        rd(8'h81, d);
        chk(d == 32'h110, "R4 lowest", d, 32'h110);
        chk_cpu("R5", 1'b1, 1'b0, 2'd1, 8'h10);
        irq_in = 16'h8401;
        tick(4);
        chk_cpu("R5 highest", 1'b1, 1'b0, 2'd3, 8'h50);
        rd(8'h83, d);
        chk(d == 32'h150, "R4", d, 32'h150);
        rd(8'h81, d);
        chk(d == 32'h110, "R4", d, 32'h110);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        lvl_mask = 4'b1000;
        #1;
        chk(valid_req == 4'b0101, "R6 level", 32'(valid_req), 4'b0101);
        tick(1);
        chk_cpu("R6", 1'b1, 1'b0, 2'd1, 8'h10);
        lvl_mask = 4'b1010;
        #1;
        chk(valid_req == '0, "R6 level", 32'(valid_req), 0);
        tick(1);
        chk_cpu("R6", 1'b0, 1'b0, 2'd0, '0);
        rd(8'h81, d);
        chk(d == 0, "R4 masked", d, 0);
        lvl_mask = 4'b0000;
        glob_mask = 1'b1;
        #1;
        chk(valid_req == '0, "R6 global", 32'(valid_req), 0);
        tick(1);
        chk_cpu("R6 global", 1'b0, 1'b0, 2'd0, '0);
        settle();
    endtask

    task automatic t_nmi();
        glob_mask = 1'b1;
        lvl_mask = 4'hF;
        irq_in = 16'h00FF;
        nmi_in = 1'b1;
        tick(3);
        chk(cpu_nmi == 1'b0, "R7 early", 32'(cpu_nmi), 0);
        tick(1);
        chk_cpu("R7", 1'b1, 1'b1, 2'd3, 8'hFC);
        settle();
        chk_cpu("R7 release", 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h82, 32'hFFFF_FFFF);
        tick(1);
        rd(8'h41, d);
        chk(d == 0, "R8 req", d, 0);
        rd(8'h82, d);
        chk(d == 0, "R8 cause", d, 0);
        rd(8'h01, d);
        chk(d == 32'h224, "R8 prio", d, 32'h224);
        chk_cpu("R8", 1'b0, 1'b0, 2'd0, '0);
        chk(valid_req == '0, "R8", 32'(valid_req), 0);
    endtask

    task automatic t_ingroup();
        logic [31:0] d;
        irq_in = 16'h00F0;
        tick(3);
        chk(valid_req == 4'b0010, "R9", 32'(valid_req), 4'b0010);
        rd(8'h41, d);
        chk(d == 32'hF, "R9", d, 32'hF);
        tick(1);
        chk_cpu("R9", 1'b1, 1'b0, 2'd2, 8'h24);
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_single();
        t_lowest();
        t_mask();
        t_nmi();
        t_ignore();
        t_ingroup();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule